// File: doc/BRIEF.md
# SDRAM power-up and refresh sequencer

This block sits on the controller side of a single-data-rate SDRAM and owns the command bus while the memory is brought up and whenever a refresh is due. After reset it holds clock enable and all byte masks high and drives no-operation commands for the power-up pause. It then precharges every bank and writes the standard mode register. Next it writes the extended mode register, which holds the self-refresh array size, the temperature range and the output drive strength. A configured number of auto-refresh cycles follow, and then it declares the memory ready.

From then on a refresh timer runs from the most recent refresh command. Ahead of each deadline the block raises a request to the bus arbiter. The arbiter is expected to close all banks and then grant. The refresh is issued in the cycle after the grant is seen, and the request is held until the refresh recovery time has elapsed, so the arbiter knows when the bus is free again. Every wait is given in nanoseconds and converted to whole clock cycles, rounding up (the refresh interval rounds down).

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is asserted and for exactly PWR_CYC = ceil(POWERUP_NS/CLK_NS) cycles after reset is released, the bus carries NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1) with CKE high, DQM all ones, ready low and ref_req low.
- R2: The next cycle carries precharge-all: CS#,RAS#,CAS#,WE# = 0,0,1,0, address bit 10 high and all other address and bank bits low.
- R3: The mode register write (CS#,RAS#,CAS#,WE# = 0,0,0,0, BA = 00) comes TRP_CYC = max(2, ceil(TRP_NS/CLK_NS)) cycles after precharge-all. The address carries burst length in bits 2..0, burst type in bit 3, CAS latency in bits 6..4, the single-location-write flag in bit 9, and zeros elsewhere.
- R4: The extended mode register write (same command, BA = 10) comes MRD_CYC = max(2, TMRD_CYC) cycles after the mode register write. The address carries the self-refresh array size in bits 2..0, the temperature range in bits 4..3, the drive strength in bits 6..5 (00 full, 01 half), and zeros elsewhere.
- R5: INIT_REFS auto-refresh commands (CS#,RAS#,CAS#,WE# = 0,0,0,1, CKE high) follow. The first comes MRD_CYC cycles after the extended write, and each later one comes TRC_CYC = max(2, ceil(TRC_NS/CLK_NS)) cycles after the one before it.
- R6: ready rises TRC_CYC cycles after the last initial refresh and then stays high; DQM is all zeros while ready is high.
- R7: Every cycle between two commands carries NOP.
- R8: ref_req rises REQ_AT = REFI_CYC - LEAD_CYC cycles after the previous refresh command, where REFI_CYC = floor(REFI_NS/CLK_NS) and LEAD_CYC = ceil(LEAD_NS/CLK_NS). It is never high before ready.
- R9: A periodic refresh is issued in the cycle after ref_gnt is sampled high while ref_req is high. Without a grant the refresh is withheld and ref_req stays high.
- R10: ref_req stays high through the refresh and falls exactly TRC_CYC cycles after the refresh command.
- R11: ref_gnt sampled high while ref_req is low has no effect: the bus stays at NOP.
- R12: If the grant is sampled within LEAD_CYC cycles of ref_req rising, consecutive refresh commands are at most REFI_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grant for a pending refresh |
| ref_req | output | 1 | Refresh request to the arbiter, held until recovery ends |
| ready | output | 1 | Initialization complete |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select |
| addr | output | ADDR_W | Address / register opcode |
| dqm | output | DQM_W | Byte masks |

## Verification
The hardest case to reach from the ports is a grant that arrives after the lead window. In that case the refresh must stay withheld while the request is held, and the next request must be timed from the late refresh rather than from the missed deadline. The stimulus reaches it with a directed round that delays the grant to several times the lead window. That round sits among rounds with grant delays drawn at random within the window, plus the zero-delay and last-legal-cycle corners. A grant held high in the idle gap before a request checks that stray grants are ignored.

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq #(
  parameter int CLK_NS     = 8,
  parameter int POWERUP_NS = 200000,
  parameter int TRP_NS     = 20,
  parameter int TRC_NS     = 65,
  parameter int TMRD_CYC   = 2,
  parameter int REFI_NS    = 15625,
  parameter int LEAD_NS    = 1000,
  parameter int INIT_REFS  = 2,
  parameter int ADDR_W     = 12,
  parameter int DQM_W      = 4,
  parameter logic [2:0] BURST_LEN    = 3'b011,
  parameter logic       BURST_TYPE   = 1'b0,
  parameter logic [2:0] CAS_LAT      = 3'b011,
  parameter logic       WRITE_SINGLE = 1'b0,
  parameter logic [2:0] PASR         = 3'b000,
  parameter logic [1:0] TEMP_RANGE   = 2'b00,
  parameter logic [1:0] DRIVE        = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ready,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm
);

  localparam int PWR_CYC  = (POWERUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int TRP_RAW  = (TRP_NS + CLK_NS - 1) / CLK_NS;
  localparam int TRC_RAW  = (TRC_NS + CLK_NS - 1) / CLK_NS;
  localparam int TRP_GAP  = (TRP_RAW < 2) ? 2 : TRP_RAW;
  localparam int TRC_GAP  = (TRC_RAW < 2) ? 2 : TRC_RAW;
  localparam int MRD_GAP  = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int REFI_CYC = REFI_NS / CLK_NS;
  localparam int LEAD_CYC = (LEAD_NS + CLK_NS - 1) / CLK_NS;
  localparam int REQ_AT   = REFI_CYC - LEAD_CYC;
  localparam int MAX_A    = (PWR_CYC > TRC_GAP) ? PWR_CYC : TRC_GAP;
  localparam int MAX_B    = (TRP_GAP > MRD_GAP) ? TRP_GAP : MRD_GAP;
  localparam int CNT_MAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int TMR_W    = $clog2(REFI_CYC + 1);
  localparam int NREF_W   = $clog2(INIT_REFS + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;

  localparam logic [ADDR_W-1:0] PRE_WORD  = ADDR_W'(11'h400);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({WRITE_SINGLE, 2'b00, CAS_LAT, BURST_TYPE, BURST_LEN});
  localparam logic [ADDR_W-1:0] EXT_WORD  = ADDR_W'({DRIVE, TEMP_RANGE, PASR});

  typedef enum logic [3:0] {
    S_PWR, S_PRE, S_WPRE, S_MRS, S_WMRS, S_EMRS, S_WEMRS,
    S_IREF, S_WIREF, S_IDLE, S_REQ, S_REF, S_WREF
  } st_t;

  st_t               state;
  logic [CNT_W-1:0]  cnt;
  logic [TMR_W-1:0]  tmr;
  logic [NREF_W-1:0] nref;
  logic [3:0]        cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_PWR;
      cnt   <= CNT_W'(PWR_CYC);
      nref  <= '0;
    end else begin
      case (state)
        S_PWR:   if (cnt == 0) state <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE:   begin cnt <= CNT_W'(TRP_GAP - 2); state <= S_WPRE; end
        S_WPRE:  if (cnt == 0) state <= S_MRS; else cnt <= cnt - 1'b1;
        S_MRS:   begin cnt <= CNT_W'(MRD_GAP - 2); state <= S_WMRS; end
        S_WMRS:  if (cnt == 0) state <= S_EMRS; else cnt <= cnt - 1'b1;
        S_EMRS:  begin cnt <= CNT_W'(MRD_GAP - 2); state <= S_WEMRS; end
        S_WEMRS: if (cnt == 0) state <= S_IREF; else cnt <= cnt - 1'b1;
        S_IREF: begin
          cnt   <= CNT_W'(TRC_GAP - 2);
          nref  <= nref + 1'b1;
          state <= S_WIREF;
        end
        S_WIREF:
          if (cnt != 0) cnt <= cnt - 1'b1;
          else state <= (nref == NREF_W'(INIT_REFS)) ? S_IDLE : S_IREF;
        S_IDLE:  if (tmr >= TMR_W'(REQ_AT - 1)) state <= S_REQ;
        S_REQ:   if (ref_gnt) state <= S_REF;
        S_REF:   begin cnt <= CNT_W'(TRC_GAP - 2); state <= S_WREF; end
        S_WREF:  if (cnt == 0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        default: state <= S_PWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tmr <= '0;
    else if (state == S_IREF || state == S_REF) tmr <= TMR_W'(1);
    else if (tmr != {TMR_W{1'b1}}) tmr <= tmr + 1'b1;
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = 2'b00;
    addr = '0;
    case (state)
      S_PRE:          begin cmd = C_PRE; addr = PRE_WORD; end
      S_MRS:          begin cmd = C_MRS; addr = MODE_WORD; end
      S_EMRS:         begin cmd = C_MRS; ba = 2'b10; addr = EXT_WORD; end
      S_IREF, S_REF:  cmd = C_REF;
      default:        cmd = C_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke     = 1'b1;
  assign ready   = (state == S_IDLE) || (state == S_REQ) ||
                   (state == S_REF)  || (state == S_WREF);
  assign ref_req = (state == S_REQ) || (state == S_REF) || (state == S_WREF);
  assign dqm     = {DQM_W{~ready}};

  logic [3:0]       last_cmd;
  logic [CNT_W-1:0] since;
  logic             issued;
  assign issued = (cmd != C_NOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_cmd <= C_NOP;
      since    <= '0;
    end else if (issued) begin
      last_cmd <= cmd;
      since    <= CNT_W'(1);
    end else if (since != {CNT_W{1'b1}}) begin
      since <= since + 1'b1;
    end
  end

  // R3
  trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issued && last_cmd == C_PRE |-> since >= CNT_W'(TRP_GAP));
  // R4
  mrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issued && last_cmd == C_MRS |-> since >= CNT_W'(MRD_GAP));
  // R5
  trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issued && last_cmd == C_REF |-> since >= CNT_W'(TRC_GAP));
  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R8
  no_req_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !ref_req);
  // R9
  ref_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF && ready) |-> $past(ref_gnt && ref_req));
  // R10
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req) |-> (last_cmd == C_REF && since == CNT_W'(TRC_GAP)));

endmodule

// File: tb/test_sdram_init_refresh_seq.sv
module test_sdram_init_refresh_seq;
  localparam int CLK_NS = 10, POWERUP_NS = 500, TRP_NS = 20, TRC_NS = 65;
  localparam int REFI_NS = 1000, LEAD_NS = 200, INIT_REFS = 2;
  localparam logic [2:0] BL = 3'b011, CL = 3'b010, PS = 3'b101;
  localparam logic       BT = 1'b1, WS = 1'b1;
  localparam logic [1:0] TR = 2'b01, DS = 2'b01;

  localparam int P      = (POWERUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int TRP    = 2;
  localparam int TRC    = 7;
  localparam int MRD    = 2;
  localparam int REFI   = REFI_NS / CLK_NS;
  localparam int LEAD   = (LEAD_NS + CLK_NS - 1) / CLK_NS;
  localparam int REQ_AT = REFI - LEAD;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, MRS = 4'b0000, REF = 4'b0001;

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic ref_req, ready, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;
  logic [3:0] dqm;

  int vectors = 0, miscompares = 0, cyc = 0, last_ref = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_init_refresh_seq #(
    .CLK_NS(CLK_NS), .POWERUP_NS(POWERUP_NS), .TRP_NS(TRP_NS), .TRC_NS(TRC_NS),
    .TMRD_CYC(2), .REFI_NS(REFI_NS), .LEAD_NS(LEAD_NS), .INIT_REFS(INIT_REFS),
    .ADDR_W(12), .DQM_W(4), .BURST_LEN(BL), .BURST_TYPE(BT), .CAS_LAT(CL),
    .WRITE_SINGLE(WS), .PASR(PS), .TEMP_RANGE(TR), .DRIVE(DS)
  ) i_sdram_init_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .ready(ready),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .dqm(dqm)
  );

  function automatic logic [11:0] mode_word();
    logic [11:0] w = '0;
    w[2:0] = BL; w[3] = BT; w[6:4] = CL; w[9] = WS;
    return w;
  endfunction

  function automatic logic [11:0] ext_word();
    logic [11:0] w = '0;
    w[2:0] = PS; w[4:3] = TR; w[6:5] = DS;
    return w;
  endfunction

  task automatic expect_now(input logic [3:0] ec, input logic [1:0] eba,
                            input logic [11:0] ea, input logic ereq,
                            input logic erdy, input string tag);
    logic [3:0] ac;
    logic [3:0] edqm;
    ac   = {cs_n, ras_n, cas_n, we_n};
    edqm = erdy ? 4'h0 : 4'hf;
    vectors++;
    if (ac !== ec || ba !== eba || addr !== ea || ref_req !== ereq ||
        ready !== erdy || dqm !== edqm || cke !== 1'b1) begin
      miscompares++;
      $display("FAIL %s cyc=%0d: cmd=%b ba=%b a=%h req=%b rdy=%b dqm=%h cke=%b expected cmd=%b ba=%b a=%h req=%b rdy=%b dqm=%h cke=1",
               tag, cyc, ac, ba, addr, ref_req, ready, dqm, cke,
               ec, eba, ea, ereq, erdy, edqm);
    end
  endtask

  task automatic step(input logic [3:0] ec, input logic [1:0] eba,
                      input logic [11:0] ea, input logic ereq,
                      input logic erdy, input string tag);
    @(negedge clk);
    cyc++;
    expect_now(ec, eba, ea, ereq, erdy, tag);
  endtask

  task automatic nops(input int n, input logic ereq, input logic erdy, input string tag);
    for (int i = 0; i < n; i++) step(NOP, 2'b00, 12'h000, ereq, erdy, tag);
  endtask

  task automatic round(input int d, input bit stray, input bit first);
    step(NOP, 2'b00, 12'h000, 1'b0, 1'b1, first ? "R6 ready rise" : "R10 req release");
    if (stray) ref_gnt = 1'b1;
    nops(REQ_AT - TRC - 2, 1'b0, 1'b1, "R11 stray grant");
    ref_gnt = 1'b0;
    nops(1, 1'b0, 1'b1, "R8 before request");
    step(NOP, 2'b00, 12'h000, 1'b1, 1'b1, "R8 request rise");
    nops(d, 1'b1, 1'b1, "R9 withheld without grant");
    ref_gnt = 1'b1;
    step(REF, 2'b00, 12'h000, 1'b1, 1'b1, "R9 refresh after grant");
    ref_gnt = 1'b0;
    vectors++;
    if (cyc - last_ref != REQ_AT + d + 1 || (d < LEAD && cyc - last_ref > REFI)) begin
      miscompares++;
      $display("FAIL R12 refresh spacing: actual=%0d expected=%0d (limit %0d)",
               cyc - last_ref, REQ_AT + d + 1, REFI);
    end
    last_ref = cyc;
    nops(TRC - 1, 1'b1, 1'b1, "R10 req held");
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    expect_now(NOP, 2'b00, 12'h000, 1'b0, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    nops(P, 1'b0, 1'b0, "R1 power-up pause");
    step(PRE, 2'b00, 12'h400, 1'b0, 1'b0, "R2 precharge-all");
    nops(TRP - 1, 1'b0, 1'b0, "R7 after precharge");
    step(MRS, 2'b00, mode_word(), 1'b0, 1'b0, "R3 mode write");
    nops(MRD - 1, 1'b0, 1'b0, "R7 after mode write");
    step(MRS, 2'b10, ext_word(), 1'b0, 1'b0, "R4 extended write");
    nops(MRD - 1, 1'b0, 1'b0, "R7 after extended write");
    for (int k = 0; k < INIT_REFS; k++) begin
      step(REF, 2'b00, 12'h000, 1'b0, 1'b0, "R5 init refresh");
      nops(TRC - 1, 1'b0, 1'b0, "R5 refresh recovery");
    end
    last_ref = cyc - (TRC - 1);
    round(0, 1'b1, 1'b1);
    round(LEAD - 1, 1'b0, 1'b0);
    round(3 * LEAD, 1'b1, 1'b0);
    for (int r = 0; r < 6; r++) round(int'($urandom % LEAD), r[0], 1'b0);
    nops(1, 1'b0, 1'b1, "R10 final release");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule